// File: doc/BRIEF.md
# GPIO Port Register Controller

This block gives software a word-wide register window onto a bank of general-purpose pins. Each pin carries a direction bit, a bit in the output latch and a two-bit function selector. The pad side sees three things. The output-enable vector is high for a pin set as an output whose selector is zero. The output-value vector shows the latch. The selector vector goes to an external pad mux. Incoming pad levels pass through a two-stage synchroniser before software can read them.

The register window is arranged by feature. Each feature owns one 32-bit word per 32 pins. The function selectors pack 16 pins into each word, so they take twice as many words. The latch is never written whole. One strobe word sets the bits written as 1, and another clears them, so no read-modify-write is needed. Three feature slots are kept for a separate edge-detection block and read as zero here. The pin count is a parameter, either 64 or 96.

Top module: `gpio_port_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, every pin becomes an input, the output latch and all function selectors become 0, and `bus_rdata` becomes 0.
- R2: With P = NUM_PINS/32, the byte address of word w of feature slot f is f*P*4 + w*4. The slots in order are: 0 level, 1 direction, 2 set, 3 clear, 4 to 6 reserved, 7 function select (2*P words). In the level, direction, set and clear words, pin n sits in word n/32 at bit n mod 32.
- R3: Direction bit 1 makes a pin an output and 0 makes it an input. `pad_oe[n]` is 1 exactly when the direction bit of pin n is 1 and its selector field is 0.
- R4: Writing to a set word drives high the latch bits written as 1. Bits written as 0 keep their value.
- R5: Writing to a clear word drives low the latch bits written as 1. Bits written as 0 keep their value.
- R6: `pad_out` always shows the output latch, and reading a set word or a clear word returns that latch word.
- R7: Reading a level word returns `pad_in` delayed by two clock edges. Writes to level words are ignored.
- R8: Pin n's two-bit selector sits in function word n/16 at bit (n mod 16)*2. Written words read back unchanged and appear on `alt_sel[2n+1:2n]`. A nonzero field forces `pad_oe[n]` low.
- R9: A write to a reserved slot, to an address past the map, or to an address with nonzero low two bits changes no output. A read of any of them returns 0.
- R10: `bus_rdata` appears one clock after the address is presented. It shows the state from before any write taking effect at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | ADDR_W | Byte address of the register word |
| bus_we | input | 1 | Write strobe for this cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | NUM_PINS | Raw pad levels |
| pad_oe | output | NUM_PINS | Pad driver enable per pin |
| pad_out | output | NUM_PINS | Pad driver value per pin |
| alt_sel | output | 2*NUM_PINS | Function selector per pin, 2 bits each |

## Verification
The assertions assume that `bus_addr` and `bus_we` are known after reset. They also assume that a cycle without a write leaves the register state alone, so the pad outputs only move at a write edge. The bench holds reset low from time zero and only changes the bus and `pad_in` at falling edges. It sends one access per cycle. Random traffic is kept inside the window just past the map, so the decoded slots, the reserved slots, the unaligned addresses and the out-of-map addresses are all hit, with arbitrary pad levels that may change in any cycle.

// File: rtl/gpio_port_pkg.sv
// Shared constants and the feature-slot type for the GPIO port controller.
// Assumes a 32-bit register bus.
package gpio_port_pkg;
    localparam int BUS_W         = 32;
    localparam int PINS_PER_WORD = 32;
    localparam int SEL_PER_WORD  = 16;
    localparam int SLOT_COUNT    = 7;   // slots below the selector slot

    // Slot order sets the address layout and must stay as listed.
    typedef enum logic [3:0] {
        SLOT_LEVEL = 4'd0,
        SLOT_DIR   = 4'd1,
        SLOT_SET   = 4'd2,
        SLOT_CLR   = 4'd3,
        SLOT_RSV_A = 4'd4,
        SLOT_RSV_B = 4'd5,
        SLOT_RSV_C = 4'd6,
        SLOT_SEL   = 4'd7,
        SLOT_NONE  = 4'd15
    } gpio_slot_e;
endpackage

// File: rtl/gpio_in_sync.sv
// Two-stage synchroniser, one flop pair per bit.
// Assumes each bit is independent; no bus coherency is promised across bits.
module gpio_in_sync #(
    parameter int WIDTH = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic meta_q, stab_q;
        // Move the raw level through two flops.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                stab_q <= 1'b0;
            end else begin
                meta_q <= d_async[b];
                stab_q <= meta_q;
            end
        end
        assign q_sync[b] = stab_q;
    end
endmodule

// File: rtl/gpio_addr_decode.sv
// Splits a byte address into a feature slot and a word index within it.
// Assumes NUM_PINS is a multiple of 32. Addresses with nonzero low two bits map to no slot.
module gpio_addr_decode
    import gpio_port_pkg::*;
#(
    parameter int NUM_PINS = 64,
    parameter int ADDR_W   = 8,
    parameter int WORD_W   = 2
) (
    input  logic [ADDR_W-1:0] addr,
    output gpio_slot_e        slot,
    output logic [WORD_W-1:0] word,
    output logic              hit
);
    localparam int WPF = NUM_PINS / PINS_PER_WORD;

    int word_no;

    // Find which slot range the word number falls in.
    always_comb begin
        word_no = int'(addr >> 2);
        slot    = SLOT_NONE;
        word    = '0;
        if (addr[1:0] == 2'b00) begin
            for (int s = 0; s < SLOT_COUNT; s++) begin
                if (word_no >= s * WPF && word_no < (s + 1) * WPF) begin
                    slot = gpio_slot_e'(4'(s));
                    word = WORD_W'(word_no - s * WPF);
                end
            end
            if (word_no >= SLOT_COUNT * WPF && word_no < (SLOT_COUNT + 2) * WPF) begin
                slot = SLOT_SEL;
                word = WORD_W'(word_no - SLOT_COUNT * WPF);
            end
        end
    end

    // Flag the slots this block actually implements.
    always_comb begin
        hit = (slot == SLOT_LEVEL) || (slot == SLOT_DIR) || (slot == SLOT_SET) ||
              (slot == SLOT_CLR)   || (slot == SLOT_SEL);
    end
endmodule

// File: rtl/gpio_pin_regs.sv
// Per-pin state: direction, output latch and function selectors, one word per generate slice.
// Assumes at most one write strobe is high per cycle.
module gpio_pin_regs
    import gpio_port_pkg::*;
#(
    parameter int NUM_PINS = 64,
    parameter int WORD_W   = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_dir,
    input  logic                  wr_set,
    input  logic                  wr_clr,
    input  logic                  wr_sel,
    input  logic [WORD_W-1:0]     word,
    input  logic [BUS_W-1:0]      wdata,
    output logic [NUM_PINS-1:0]   dir_q,
    output logic [NUM_PINS-1:0]   lat_q,
    output logic [2*NUM_PINS-1:0] sel_q
);
    localparam int WPF     = NUM_PINS / PINS_PER_WORD;
    localparam int SEL_WDS = 2 * WPF;

    for (genvar w = 0; w < WPF; w++) begin : g_pinword
        logic [BUS_W-1:0] dir_r, lat_r;
        logic             here;
        assign here = (word == WORD_W'(w));
        // Update this word's direction and latch bits.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                dir_r <= '0;
                lat_r <= '0;
            end else begin
                if (wr_dir && here) dir_r <= wdata;
                if (wr_set && here)      lat_r <= lat_r | wdata;
                else if (wr_clr && here) lat_r <= lat_r & ~wdata;
            end
        end
        assign dir_q[w*BUS_W +: BUS_W] = dir_r;
        assign lat_q[w*BUS_W +: BUS_W] = lat_r;
    end

    for (genvar k = 0; k < SEL_WDS; k++) begin : g_selword
        logic [BUS_W-1:0] sel_r;
        // Store one word of 16 selector fields.
        always_ff @(posedge clk) begin
            if (!rst_n)                              sel_r <= '0;
            else if (wr_sel && word == WORD_W'(k))   sel_r <= wdata;
        end
        assign sel_q[k*BUS_W +: BUS_W] = sel_r;
    end

    // R4
    set_no_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> ((lat_q & $past(lat_q)) == $past(lat_q)));
    // R5
    clr_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> ((lat_q & ~$past(lat_q)) == '0));
endmodule

// File: rtl/gpio_port_ctrl.sv
// GPIO port controller top: register window, registered read path and pad-side outputs.
// Assumes NUM_PINS is 64 or 96 and the address space covers (9*NUM_PINS/32) words.
module gpio_port_ctrl
    import gpio_port_pkg::*;
#(
    parameter int NUM_PINS = 64,
    parameter int ADDR_W   = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  bus_we,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           bus_rdata,
    input  logic [NUM_PINS-1:0]   pad_in,
    output logic [NUM_PINS-1:0]   pad_oe,
    output logic [NUM_PINS-1:0]   pad_out,
    output logic [2*NUM_PINS-1:0] alt_sel
);
    localparam int WPF     = NUM_PINS / PINS_PER_WORD;
    localparam int SEL_WDS = 2 * WPF;
    localparam int WORD_W  = $clog2(SEL_WDS);

    gpio_slot_e          slot;
    logic [WORD_W-1:0]   word;
    logic                map_hit;
    logic [NUM_PINS-1:0] level, dir_q, lat_q;
    logic [2*NUM_PINS-1:0] sel_q;
    logic [31:0]         rd_next;

    gpio_addr_decode #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_dec (
        .addr(bus_addr), .slot(slot), .word(word), .hit(map_hit)
    );

    gpio_in_sync #(.WIDTH(NUM_PINS)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_async(pad_in), .q_sync(level)
    );

    gpio_pin_regs #(.NUM_PINS(NUM_PINS), .WORD_W(WORD_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_dir(bus_we && slot == SLOT_DIR),
        .wr_set(bus_we && slot == SLOT_SET),
        .wr_clr(bus_we && slot == SLOT_CLR),
        .wr_sel(bus_we && slot == SLOT_SEL),
        .word(word), .wdata(bus_wdata),
        .dir_q(dir_q), .lat_q(lat_q), .sel_q(sel_q)
    );

    // Choose the word to return for the decoded slot.
    always_comb begin
        rd_next = '0;
        for (int k = 0; k < WPF; k++) begin
            if (word == WORD_W'(k)) begin
                case (slot)
                    SLOT_LEVEL:        rd_next = level[k*32 +: 32];
                    SLOT_DIR:          rd_next = dir_q[k*32 +: 32];
                    SLOT_SET, SLOT_CLR: rd_next = lat_q[k*32 +: 32];
                    default:           ;
                endcase
            end
        end
        for (int k = 0; k < SEL_WDS; k++) begin
            if (slot == SLOT_SEL && word == WORD_W'(k)) rd_next = sel_q[k*32 +: 32];
        end
    end

    // Register the read word one cycle after the address.
    always_ff @(posedge clk) begin
        if (!rst_n) bus_rdata <= '0;
        else        bus_rdata <= rd_next;
    end

    for (genvar n = 0; n < NUM_PINS; n++) begin : g_pad
        assign pad_oe[n] = dir_q[n] & (sel_q[2*n +: 2] == 2'b00);
    end
    assign pad_out = lat_q;
    assign alt_sel = sel_q;

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (pad_oe == '0 && pad_out == '0 && alt_sel == '0 && bus_rdata == '0));
    // R9
    miss_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !map_hit) |=> ($stable(pad_oe) && $stable(pad_out) && $stable(alt_sel)));
    // R9
    miss_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !map_hit |=> (bus_rdata == '0));
    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> ($stable(pad_oe) && $stable(pad_out) && $stable(alt_sel)));
endmodule

// File: tb/gpio_port_ctrl_test.sv
`timescale 1ns/1ps
module gpio_port_ctrl_test;
    localparam int NP = 64;
    localparam int W  = NP / 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [7:0]      bus_addr = '0;
    logic            bus_we = 1'b0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [NP-1:0]   pad_in = '0;
    logic [NP-1:0]   pad_oe, pad_out;
    logic [2*NP-1:0] alt_sel;

    int n_cmp = 0;
    int n_bad = 0;

    // Reference state
    logic [NP-1:0]   m_dir, m_lat, m_s1, m_s2;
    logic [2*NP-1:0] m_sel;

    always #2 clk = ~clk;

    gpio_port_ctrl #(.NUM_PINS(NP), .ADDR_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_oe(pad_oe), .pad_out(pad_out), .alt_sel(alt_sel)
    );

    function automatic logic [31:0] m_read(input int a);
        int idx, f, w;
        if (a % 4 != 0) return '0;
        idx = a / 4;
        f = idx / W;
        w = idx % W;
        if (f == 0) return m_s2[w*32 +: 32];
        if (f == 1) return m_dir[w*32 +: 32];
        if (f == 2 || f == 3) return m_lat[w*32 +: 32];
        if (idx >= 7 * W && idx < 9 * W) return m_sel[(idx - 7 * W)*32 +: 32];
        return '0;
    endfunction

    task automatic m_write(input int a, input logic [31:0] d);
        int idx, f, w;
        if (a % 4 != 0) return;
        idx = a / 4;
        f = idx / W;
        w = idx % W;
        if (f == 1) m_dir[w*32 +: 32] = d;
        else if (f == 2) m_lat[w*32 +: 32] = m_lat[w*32 +: 32] | d;
        else if (f == 3) m_lat[w*32 +: 32] = m_lat[w*32 +: 32] & ~d;
        else if (idx >= 7 * W && idx < 9 * W) m_sel[(idx - 7 * W)*32 +: 32] = d;
    endtask

    task automatic check(input string tag, input string what,
                         input logic [2*NP-1:0] act, input logic [2*NP-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic step(input logic r, input int a, input logic we,
                        input logic [31:0] d, input logic [NP-1:0] p, input string tag);
        logic [31:0]   e_rd;
        logic [NP-1:0] e_oe;
        @(negedge clk);
        rst_n = r; bus_addr = 8'(a); bus_we = we; bus_wdata = d; pad_in = p;
        @(posedge clk);
        #1;
        if (!r) begin
            m_dir = '0; m_lat = '0; m_sel = '0; m_s1 = '0; m_s2 = '0;
            e_rd = '0;
        end else begin
            e_rd = m_read(a);
            if (we) m_write(a, d);
            m_s2 = m_s1;
            m_s1 = p;
        end
        for (int n = 0; n < NP; n++) e_oe[n] = m_dir[n] && (m_sel[2*n +: 2] == 2'b00);
        check(tag, "rdata", {{(2*NP-32){1'b0}}, bus_rdata}, {{(2*NP-32){1'b0}}, e_rd});
        check(tag, "pad_oe", {{NP{1'b0}}, pad_oe}, {{NP{1'b0}}, e_oe});
        check(tag, "pad_out", {{NP{1'b0}}, pad_out}, {{NP{1'b0}}, m_lat});
        check(tag, "alt_sel", alt_sel, m_sel);
    endtask

    initial begin : watchdog
        #(200000 * 4);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        logic [NP-1:0] pv;
        // R1: reset state, with bus activity ignored
        for (int i = 0; i < 3; i++) step(1'b0, 8, 1'b1, 32'hFFFF_FFFF, '1, "R1");
        // R2, R3: direction words at their computed addresses
        step(1'b1, 1*W*4 + 0, 1'b1, 32'hF0F0_00FF, '0, "R2");
        step(1'b1, 1*W*4 + 4, 1'b1, 32'h8000_0001, '0, "R3");
        step(1'b1, 1*W*4 + 0, 1'b0, 0, '0, "R2");
        step(1'b1, 1*W*4 + 4, 1'b0, 0, '0, "R3");
        // R4: set strobes
        step(1'b1, 2*W*4 + 0, 1'b1, 32'h0000_00A5, '0, "R4");
        step(1'b1, 2*W*4 + 4, 1'b1, 32'hC000_0003, '0, "R4");
        step(1'b1, 2*W*4 + 0, 1'b1, 32'h0000_0000, '0, "R4");
        // R5: clear strobes
        step(1'b1, 3*W*4 + 0, 1'b1, 32'h0000_0021, '0, "R5");
        step(1'b1, 3*W*4 + 4, 1'b1, 32'h4000_0000, '0, "R5");
        // R6: set/clear words read back the latch
        step(1'b1, 2*W*4 + 0, 1'b0, 0, '0, "R6");
        step(1'b1, 3*W*4 + 4, 1'b0, 0, '0, "R6");
        step(1'b1, 2*W*4 + 4, 1'b0, 0, '0, "R6");
        // R7: level path with two-edge delay and write ignored
        pv = 64'hDEAD_BEEF_1234_5678;
        step(1'b1, 0, 1'b0, 0, pv, "R7");
        step(1'b1, 0, 1'b1, 32'hFFFF_FFFF, ~pv, "R7");
        step(1'b1, 4, 1'b0, 0, pv, "R7");
        step(1'b1, 0, 1'b0, 0, pv, "R7");
        step(1'b1, 4, 1'b0, 0, pv, "R7");
        // R8: selector words, readback and output-enable override
        step(1'b1, 7*W*4 + 0, 1'b1, 32'h0000_0C01, '0, "R8");
        step(1'b1, 7*W*4 + 12, 1'b1, 32'h8000_0000, '0, "R8");
        step(1'b1, 7*W*4 + 0, 1'b0, 0, '0, "R8");
        step(1'b1, 7*W*4 + 12, 1'b0, 0, '0, "R8");
        step(1'b1, 7*W*4 + 0, 1'b1, 32'h0, '0, "R8");
        // R9: reserved slots, past the map, unaligned
        for (int s = 4; s < 7; s++) begin
            step(1'b1, s*W*4, 1'b1, 32'hFFFF_FFFF, '1, "R9");
            step(1'b1, s*W*4 + 4, 1'b0, 0, '1, "R9");
        end
        step(1'b1, 9*W*4, 1'b1, 32'hFFFF_FFFF, '1, "R9");
        step(1'b1, 9*W*4, 1'b0, 0, '1, "R9");
        step(1'b1, 255, 1'b1, 32'hFFFF_FFFF, '1, "R9");
        step(1'b1, 1*W*4 + 1, 1'b1, 32'h0, '1, "R9");
        step(1'b1, 2*W*4 + 2, 1'b1, 32'hFFFF_FFFF, '1, "R9");
        step(1'b1, 1*W*4 + 0, 1'b0, 0, '1, "R9");
        // R10: read during a write returns the old value, then the new
        step(1'b1, 1*W*4 + 0, 1'b1, 32'h1357_9BDF, '0, "R10");
        step(1'b1, 1*W*4 + 0, 1'b0, 0, '0, "R10");
        // Mixed traffic
        for (int i = 0; i < 600; i++) begin
            step(1'b1, int'($urandom_range(0, 9*W*4 + 8)), 1'($urandom),
                 $urandom, {$urandom, $urandom}, "R2,R10");
        end
        // R1: reset mid-run clears everything
        step(1'b0, 0, 1'b0, 0, '1, "R1");
        step(1'b1, 1*W*4, 1'b0, 0, '1, "R1");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule